// File: doc/BRIEF.md
# DDR SDRAM Mode-Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface and performs the register-programming part of device setup. On a start request it captures the requested setup: burst length code, burst ordering, read latency code, a DLL-reset request and a two-bit extended setting. If any code is reserved, it raises an error flag and issues nothing. Otherwise it waits until the memory reports every bank precharged and the clock enable is high. It then writes the extended register and the base register, always in that order, on the command and address pins.

Each register write is a single command cycle. At least two no-operation cycles must follow it before anything else is issued. After the wait that follows the base-register write, the sequencer pulses `done` for one cycle and returns to idle. While it is idle or waiting, the pins carry a no-operation command.

Top module: `ddr_mode_prog`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and the pins carry a NOP: chip select low, the other three strobes high, bank select and address all zero.
- R2: A register write drives chip select, row strobe, column strobe and write enable all low in one cycle. Bank select 01 addresses the extended register and 00 the base register, and the extended write always comes first.
- R3: The extended-register write carries the extended setting on address bits 1..0 and 0 on every other address bit.
- R4: The base-register write carries the burst-length code on bits 2..0, the ordering on bit 3 (0 sequential, 1 interleaved), the latency code on bits 6..4, 0 on bit 7, the DLL-reset request on bit 8 and 0 on bits 11..9.
- R5: No write is issued while `banks_idle` or `cke` is low. The sequencer holds in a NOP wait until both are high.
- R6: Exactly two NOP cycles follow each register write, so the base write appears three cycles after the extended write.
- R7: `done` is a single-cycle pulse on the third cycle after the base write. `busy` is high from the cycle after an accepted start through the `done` cycle, and low after it.
- R8: Burst-length codes other than 001, 010 and 011 are reserved. In the cycle after such a start, `err` is 1, `busy` stays 0 and no write is ever issued.
- R9: Latency codes other than 010 and 011 are reserved and are rejected the same way as in R8.
- R10: A start while `busy` is high is ignored. Changes on the setup inputs after an accepted start do not alter the values written.
- R11: `err` stays set until the next start in idle, and a start with legal codes clears it in the following cycle.
- R12: When both readiness inputs are already high at the start, the extended write appears in the second cycle after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to program both registers |
| cfg_burst_len | input | 3 | Burst-length code |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Read-latency code |
| cfg_dll_reset | input | 1 | Request DLL reset in the base write |
| cfg_ext_mode | input | 2 | Extended-register setting (DLL enable, drive strength) |
| cke | input | 1 | Clock-enable level presented to the memory |
| banks_idle | input | 1 | All banks precharged |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start request carried a reserved code |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank select, register selector during writes |
| cmd_addr | output | ADDR_W | Address pins, register contents during writes |

## Verification
The outputs are Moore decodes of registered state. A value taken at edge k therefore shows at the pins just after that edge. Counting from the edge that samples `start` as edge 1, `busy` and `err` are due after edge 1, and the extended write after edge max(2, r+1) when readiness rises just after edge r. The base write follows three edges later and `done` three edges after that. The bench drives every input at the falling edge and samples every output at the next falling edge. For each cycle of a run, it compares all pins against the value expected at that cycle index.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;

  localparam int MR_W = 12;

  localparam logic [1:0] SEL_BASE = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_EXT,
    ST_GAP1,
    ST_BASE,
    ST_GAP2,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [2:0] blen;
    logic       ilv;
    logic [2:0] lat;
    logic       dll_rst;
    logic [1:0] ext;
  } mode_cfg_t;

  function automatic logic blen_legal(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic lat_legal(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic [MR_W-1:0] base_word(input mode_cfg_t c);
    logic [MR_W-1:0] w;
    w      = '0;
    w[2:0] = c.blen;
    w[3]   = c.ilv;
    w[6:4] = c.lat;
    w[7]   = 1'b0;
    w[8]   = c.dll_rst;
    return w;
  endfunction

  function automatic logic [MR_W-1:0] ext_word(input mode_cfg_t c);
    logic [MR_W-1:0] w;
    w      = '0;
    w[1:0] = c.ext;
    return w;
  endfunction

endpackage

// File: rtl/ddr_mode_legal.sv
module ddr_mode_legal
  import ddr_mode_pkg::*;
(
  input  mode_cfg_t cfg,
  output logic      cfg_ok
);

  logic blen_ok;
  logic lat_ok;

  always_comb begin
    blen_ok = blen_legal(cfg.blen);
    lat_ok  = lat_legal(cfg.lat);
    cfg_ok  = blen_ok & lat_ok;
  end

endmodule

// File: rtl/ddr_mode_seq.sv
module ddr_mode_seq
  import ddr_mode_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_ok,
  input  logic ready,
  output logic evt_accept,
  output logic evt_reject,
  output logic issue_ext,
  output logic issue_base,
  output logic done,
  output logic busy,
  output logic err_q
);

  localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

  seq_st_e          st_q;
  seq_st_e          st_d;
  logic [CNT_W-1:0] gap_cnt;
  logic             gap_end;
  logic             in_gap;

  assign gap_end    = (gap_cnt == GAP_LAST);
  assign in_gap     = (st_q == ST_GAP1) || (st_q == ST_GAP2);
  assign evt_accept = (st_q == ST_IDLE) & start & cfg_ok;
  assign evt_reject = (st_q == ST_IDLE) & start & ~cfg_ok;
  assign issue_ext  = (st_q == ST_EXT);
  assign issue_base = (st_q == ST_BASE);
  assign done       = (st_q == ST_DONE);
  assign busy       = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (evt_accept) st_d = ST_WAIT;
      ST_WAIT: if (ready)      st_d = ST_EXT;
      ST_EXT:                  st_d = ST_GAP1;
      ST_GAP1: if (gap_end)    st_d = ST_BASE;
      ST_BASE:                 st_d = ST_GAP2;
      ST_GAP2: if (gap_end)    st_d = ST_DONE;
      ST_DONE:                 st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      gap_cnt <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (in_gap && !gap_end) gap_cnt <= gap_cnt + 1'b1;
      else                    gap_cnt <= '0;
      if (st_q == ST_IDLE && start) err_q <= ~cfg_ok;
    end
  end

endmodule

// File: rtl/ddr_mode_cmd_enc.sv
module ddr_mode_cmd_enc
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              issue_ext,
  input  logic              issue_base,
  input  mode_cfg_t         cfg,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  logic write_cyc;
  assign write_cyc = issue_ext | issue_base;

  always_comb begin
    cs_n  = 1'b0;
    ras_n = ~write_cyc;
    cas_n = ~write_cyc;
    we_n  = ~write_cyc;
    ba    = '0;
    addr  = '0;
    if (issue_ext) begin
      ba   = BA_W'(SEL_EXT);
      addr = ADDR_W'(ext_word(cfg));
    end else if (issue_base) begin
      ba   = BA_W'(SEL_BASE);
      addr = ADDR_W'(base_word(cfg));
    end
  end

endmodule

// File: rtl/ddr_mode_prog.sv
module ddr_mode_prog
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_dll_reset,
  input  logic [1:0]        cfg_ext_mode,
  input  logic              cke,
  input  logic              banks_idle,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);

  mode_cfg_t cfg_in;
  mode_cfg_t cfg_q;
  logic      cfg_ok;
  logic      mem_ready;
  logic      evt_accept;
  logic      evt_reject;
  logic      issue_ext;
  logic      issue_base;

  assign cfg_in = '{blen:    cfg_burst_len,
                    ilv:     cfg_interleave,
                    lat:     cfg_cas_lat,
                    dll_rst: cfg_dll_reset,
                    ext:     cfg_ext_mode};

  assign mem_ready = banks_idle & cke;

  always_ff @(posedge clk) begin
    if (!rst_n)          cfg_q <= '0;
    else if (evt_accept) cfg_q <= cfg_in;
  end

  ddr_mode_legal u_legal (
    .cfg    (cfg_in),
    .cfg_ok (cfg_ok)
  );

  ddr_mode_seq #(
    .GAP_CYC (GAP_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_ok     (cfg_ok),
    .ready      (mem_ready),
    .evt_accept (evt_accept),
    .evt_reject (evt_reject),
    .issue_ext  (issue_ext),
    .issue_base (issue_base),
    .done       (done),
    .busy       (busy),
    .err_q      (err)
  );

  ddr_mode_cmd_enc #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_enc (
    .issue_ext  (issue_ext),
    .issue_base (issue_base),
    .cfg        (cfg_q),
    .cs_n       (cmd_cs_n),
    .ras_n      (cmd_ras_n),
    .cas_n      (cmd_cas_n),
    .we_n       (cmd_we_n),
    .ba         (cmd_ba),
    .addr       (cmd_addr)
  );

endmodule

// File: rtl/ddr_mode_prog_chk.sv
module ddr_mode_prog_chk
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int GAP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              banks_idle,
  input logic              cke,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              evt_accept,
  input logic              evt_reject,
  input mode_cfg_t         cfg_q
);

  logic       mr_wr;
  logic       ext_wr;
  logic       base_wr;
  logic       ext_seen;
  logic [7:0] since_wr;

  assign mr_wr   = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  assign ext_wr  = mr_wr && (ba == BA_W'(SEL_EXT));
  assign base_wr = mr_wr && (ba == BA_W'(SEL_BASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_wr <= 8'hFF;
      ext_seen <= 1'b0;
    end else begin
      if (mr_wr)                 since_wr <= 8'd0;
      else if (since_wr != 8'hFF) since_wr <= since_wr + 8'd1;
      if (ext_wr)    ext_seen <= 1'b1;
      else if (done) ext_seen <= 1'b0;
    end
  end

  a_r2_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |-> ext_seen);

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr |-> (ext_wr || base_wr));

  a_r3_ext_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> (addr[ADDR_W-1:2] == '0));

  a_r4_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |-> (addr[7] == 1'b0 && addr[ADDR_W-1:9] == '0));

  a_r5_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> $past(banks_idle && cke));

  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr |-> (int'(since_wr) >= GAP_CYC));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> (err && !busy));

  a_r9_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !busy) |-> !mr_wr);

  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));

  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> !err);

endmodule

bind ddr_mode_prog ddr_mode_prog_chk #(
  .ADDR_W  (ADDR_W),
  .BA_W    (BA_W),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .banks_idle (banks_idle),
  .cke        (cke),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .cs_n       (cmd_cs_n),
  .ras_n      (cmd_ras_n),
  .cas_n      (cmd_cas_n),
  .we_n       (cmd_we_n),
  .ba         (cmd_ba),
  .addr       (cmd_addr),
  .evt_accept (evt_accept),
  .evt_reject (evt_reject),
  .cfg_q      (cfg_q)
);

// File: tb/ddr_mode_prog_tb.sv
`timescale 1ns/1ps
module ddr_mode_prog_tb;

  logic        clk = 1'b0;
  logic        rst_n, start, ilv, dll, cke, banks_idle;
  logic [2:0]  blen, lat;
  logic [1:0]  ext;
  logic        busy, done, err, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr_mode_prog u_dut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .cfg_burst_len (blen), .cfg_interleave (ilv), .cfg_cas_lat (lat),
    .cfg_dll_reset (dll), .cfg_ext_mode (ext), .cke (cke), .banks_idle (banks_idle),
    .busy (busy), .done (done), .err (err),
    .cmd_cs_n (cs_n), .cmd_ras_n (ras_n), .cmd_cas_n (cas_n), .cmd_we_n (we_n),
    .cmd_ba (ba), .cmd_addr (addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // kind: 0 NOP, 1 extended write, 2 base write
  task automatic chk_pins(input string req, input int kind, input logic [11:0] exp_addr);
    logic [3:0] exp_str;
    logic [1:0] exp_ba;
    exp_str = (kind == 0) ? 4'b0111 : 4'b0000;
    exp_ba  = (kind == 1) ? 2'b01 : 2'b00;
    chk(req, "strobes", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_str});
    chk(req, "bank sel", {30'd0, ba}, {30'd0, exp_ba});
    chk(req, "addr", {20'd0, addr}, {20'd0, exp_addr});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; blen = 3'b011; ilv = 1'b0; lat = 3'b011;
    dll = 1'b0; ext = 2'b00; cke = 1'b1; banks_idle = 1'b1;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "err", {31'd0, err}, 32'd0);
    chk_pins("R1", 0, 12'h000);
  endtask

  // ready_at: 0 = ready before start, else readiness rises after sampling cycle ready_at
  task automatic run_seq(input logic [2:0] b, input logic bt, input logic [2:0] c,
                         input logic d, input logic [1:0] x, input int ready_at,
                         input bit gate_cke, input bit disturb);
    int e;
    logic [11:0] base_exp;
    logic [11:0] ext_exp;
    base_exp = {3'b000, d, 1'b0, c, bt, b};
    ext_exp  = {10'd0, x};
    e = (ready_at + 1 > 2) ? ready_at + 1 : 2;
    if (ready_at > 0) begin
      if (gate_cke) cke = 1'b0;
      else          banks_idle = 1'b0;
    end
    blen = b; ilv = bt; lat = c; dll = d; ext = x;
    start = 1'b1;
    for (int cyc = 1; cyc <= e + 8; cyc++) begin
      tick;
      if (cyc == 1) start = 1'b0;
      if (cyc == e)          chk_pins("R2 R3 R12", 1, ext_exp);
      else if (cyc == e + 3) chk_pins("R2 R4 R6 R10", 2, base_exp);
      else if (cyc < e)      chk_pins("R5", 0, 12'h000);
      else                   chk_pins("R6", 0, 12'h000);
      chk("R7", "busy", {31'd0, busy}, {31'd0, (cyc <= e + 6)});
      chk("R7", "done", {31'd0, done}, {31'd0, (cyc == e + 6)});
      chk("R11", "err", {31'd0, err}, 32'd0);
      if (ready_at > 0 && cyc == ready_at) begin
        cke = 1'b1;
        banks_idle = 1'b1;
      end
      if (disturb && cyc == 2) begin
        start = 1'b1; blen = 3'b001; ilv = ~bt; lat = c ^ 3'b001; dll = ~d; ext = ~x;
      end
      if (disturb && cyc == 3) start = 1'b0;
    end
  endtask

  task automatic t_reject(input logic [2:0] b, input logic [2:0] c, input string req);
    blen = b; lat = c; ilv = 1'b0; dll = 1'b1; ext = 2'b11;
    start = 1'b1;
    tick;
    start = 1'b0;
    chk(req, "err", {31'd0, err}, 32'd1);
    chk(req, "busy", {31'd0, busy}, 32'd0);
    chk_pins(req, 0, 12'h000);
    for (int i = 0; i < 4; i++) begin
      tick;
      chk_pins(req, 0, 12'h000);
      chk(req, "busy", {31'd0, busy}, 32'd0);
      chk(req, "done", {31'd0, done}, 32'd0);
      chk("R11", "err held", {31'd0, err}, 32'd1);
    end
  endtask

  initial begin
    t_reset;
    run_seq(3'b011, 1'b0, 3'b011, 1'b1, 2'b01, 0, 1'b0, 1'b0);
    run_seq(3'b001, 1'b1, 3'b010, 1'b0, 2'b10, 0, 1'b0, 1'b0);
    run_seq(3'b010, 1'b0, 3'b010, 1'b1, 2'b11, 4, 1'b0, 1'b0);
    run_seq(3'b011, 1'b1, 3'b011, 1'b0, 2'b00, 3, 1'b1, 1'b0);
    run_seq(3'b010, 1'b1, 3'b010, 1'b1, 2'b01, 0, 1'b0, 1'b1);
    t_reject(3'b000, 3'b011, "R8");
    t_reject(3'b100, 3'b010, "R8");
    t_reject(3'b111, 3'b011, "R8");
    run_seq(3'b001, 1'b0, 3'b011, 1'b0, 2'b10, 0, 1'b0, 1'b0);
    t_reject(3'b001, 3'b001, "R9");
    t_reject(3'b010, 3'b110, "R9");
    t_reject(3'b011, 3'b000, "R9");
    run_seq(3'b011, 1'b1, 3'b010, 1'b1, 2'b11, 1, 1'b0, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule